// File: doc/BRIEF.md
# Channel-Pair Clock Selector Divider

This block makes the count-enable ticks for two neighbouring PWM channels. Both channels use one clock setup: a source choice between an oscillator tick and a bus-clock tick, and a power-of-two divide ratio. A single shared counter divides the chosen source. Each channel then applies its own gate bit, which lets ticks through, and its own bypass bit, which takes the undivided source in place of the divided one.

All logic runs on one system clock. Both sources arrive as single-cycle tick enables in that domain. Each tick output is combinational from the current source tick and the counter state, so it appears in the same cycle as the source tick that causes it. A change of ratio or source restarts the counter, so the first tick after the change always comes after a full divide interval and never after a short one. Waveform generation and register decode sit outside this block.

Top module: `pair_tick_divider`

## Requirements
- R1: While reset is asserted (rst_ni low), both tick outputs stay 0 whatever the other inputs are.
- R2: Source select value 0 takes osc_tick_i as the source. Any nonzero value (1, 2 or 3) takes bus_tick_i. The source not selected has no effect on the outputs.
- R3: With divide exponent e, the divided tick fires once for every 2^e source ticks. After a restart it fires on the 2^e-th source tick, in the same cycle as that source tick.
- R4: Exponent 0 passes every source tick straight through.
- R5: Exponent values 9 to 15 divide by 256, the same as exponent 8.
- R6: A channel whose gate bit is 0 gets no ticks. The other channel, and the shared counter, keep running.
- R7: A channel whose bypass bit is 1 outputs every selected source tick, whatever the exponent. Its gate bit still applies.
- R8: A change of the clamped exponent, or a change between oscillator and bus source, restarts the counter in that cycle. A source tick in that cycle gives no divided tick, and the next divided tick comes after a full 2^e source ticks.
- R9: Two gated, non-bypassed channels tick in exactly the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_tick_i | input | 1 | Oscillator source tick enable |
| bus_tick_i | input | 1 | Bus-clock source tick enable |
| src_sel_i | input | 2 | Source select: 0 picks oscillator, nonzero picks bus |
| div_exp_i | input | 4 | Divide exponent; ratio is 2^min(value,8) |
| gate_i | input | 2 | Per-channel tick gate, bit n for channel n |
| bypass_i | input | 2 | Per-channel bypass of the divider, bit n for channel n |
| tick_o | output | 2 | Per-channel tick enable, bit n for channel n |

## Verification
The hardest case to reach is a configuration change while the counter is part-way through an interval, with a source tick present in the same cycle as the change. The bench first brings the counter to a known zero by writing the configuration twice while no source ticks arrive. It then feeds a set number of source ticks, so the counter stops part-way through an interval. Next it changes the exponent, or moves the source from oscillator to bus, in a cycle that also carries a source tick. It checks that this cycle gives no output, and that the next tick comes only after a full new interval.

// File: rtl/pair_div_pkg.sv
package pair_div_pkg;
  localparam int unsigned PAIR_CH_DEF  = 2;
  localparam int unsigned SEL_W_DEF    = 2;
  localparam int unsigned EXP_W_DEF    = 4;
  localparam int unsigned EXP_MAX_DEF  = 8;
endpackage

// File: rtl/src_select.sv
module src_select #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             osc_tick_i,
  input  logic             bus_tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             src_tick_o,
  output logic             use_bus_o
);
  always_comb begin
    use_bus_o  = (sel_i != '0);
    src_tick_o = use_bus_o ? bus_tick_i : osc_tick_i;
  end
endmodule

// File: rtl/pow2_divider.sv
module pow2_divider #(
  parameter int unsigned EXP_W   = 4,
  parameter int unsigned EXP_MAX = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_tick_i,
  input  logic             use_bus_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             div_tick_o
);
  localparam int unsigned CNT_W = (EXP_MAX < 1) ? 1 : EXP_MAX;

  logic [EXP_W-1:0] exp_clamp, exp_q, exp_d;
  logic             bus_q, bus_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [CNT_W:0]   lim_wide;
  logic             cfg_change;

  always_comb begin
    exp_clamp  = (exp_i > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : exp_i;
    lim_wide   = ((CNT_W+1)'(1) << exp_clamp) - (CNT_W+1)'(1);
    lim        = lim_wide[CNT_W-1:0];
    cfg_change = (exp_clamp != exp_q) || (use_bus_i != bus_q);
    exp_d      = exp_clamp;
    bus_d      = use_bus_i;
    cnt_d      = cnt_q;
    div_tick_o = 1'b0;
    if (cfg_change) begin
      cnt_d = '0;
    end else if (src_tick_i) begin
      if (cnt_q == lim) begin
        cnt_d      = '0;
        div_tick_o = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      bus_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      exp_q <= exp_d;
      bus_q <= bus_d;
      cnt_q <= cnt_d;
    end
  end

  // R8
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_change |=> (cnt_q == '0));
  // R5
  exp_clamped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q <= EXP_W'(EXP_MAX));
  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_change |-> (cnt_q <= lim));
  // R3
  tick_needs_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_tick_o |-> src_tick_i);
endmodule

// File: rtl/chan_gate.sv
module chan_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_tick_i,
  input  logic div_tick_i,
  input  logic gate_i,
  input  logic bypass_i,
  output logic tick_o
);
  always_comb begin
    tick_o = rst_ni & gate_i & (bypass_i ? src_tick_i : div_tick_i);
  end

  // R6
  out_from_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> src_tick_i);
endmodule

// File: rtl/pair_tick_divider.sv
module pair_tick_divider
  import pair_div_pkg::*;
#(
  parameter int unsigned NUM_CH  = PAIR_CH_DEF,
  parameter int unsigned SEL_W   = SEL_W_DEF,
  parameter int unsigned EXP_W   = EXP_W_DEF,
  parameter int unsigned EXP_MAX = EXP_MAX_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_tick_i,
  input  logic              bus_tick_i,
  input  logic [SEL_W-1:0]  src_sel_i,
  input  logic [EXP_W-1:0]  div_exp_i,
  input  logic [NUM_CH-1:0] gate_i,
  input  logic [NUM_CH-1:0] bypass_i,
  output logic [NUM_CH-1:0] tick_o
);
  logic src_tick, use_bus, div_tick;

  src_select #(.SEL_W(SEL_W)) u_sel (
    .osc_tick_i (osc_tick_i),
    .bus_tick_i (bus_tick_i),
    .sel_i      (src_sel_i),
    .src_tick_o (src_tick),
    .use_bus_o  (use_bus)
  );

  pow2_divider #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_tick_i (src_tick),
    .use_bus_i  (use_bus),
    .exp_i      (div_exp_i),
    .div_tick_o (div_tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chan_gate u_gate (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .src_tick_i (src_tick),
      .div_tick_i (div_tick),
      .gate_i     (gate_i[c]),
      .bypass_i   (bypass_i[c]),
      .tick_o     (tick_o[c])
    );
  end
endmodule

// File: tb/pair_tick_divider_test.sv
`timescale 1ns/1ps
module pair_tick_divider_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc, bus;
  logic [1:0] sel;
  logic [3:0] dexp;
  logic [1:0] gate, byp;
  logic [1:0] tick;
  int nvec = 0;
  int nbad = 0;

  always #2.5 clk = ~clk;

  pair_tick_divider uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc), .bus_tick_i(bus),
    .src_sel_i(sel), .div_exp_i(dexp), .gate_i(gate), .bypass_i(byp),
    .tick_o(tick)
  );

  task automatic chk(input string req, input int act, input int expv);
    nvec++;
    if (act != expv) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // zero the counter: two config writes with no source ticks
  task automatic reload(input logic [3:0] e, input logic [1:0] s);
    @(negedge clk); osc = 0; bus = 0; sel = s; dexp = (e == 0) ? 4'd1 : 4'd0;
    @(negedge clk); dexp = e;
    @(negedge clk);
  endtask

  task automatic run(input int n, input logic o, input logic b,
                     output int c0, output int c1, output int f0, output int f1);
    c0 = 0; c1 = 0; f0 = -1; f1 = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc = o; bus = b;
      #1;
      if (tick[0]) begin c0++; if (f0 < 0) f0 = i; end
      if (tick[1]) begin c1++; if (f1 < 0) f1 = i; end
    end
    @(negedge clk); osc = 0; bus = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; osc = 1; bus = 1; sel = 0; dexp = 0; gate = 2'b11; byp = 2'b11;
    repeat (3) @(negedge clk);
    #1 chk("R1 reset ticks", int'(tick), 0);
    @(negedge clk); osc = 0; bus = 0; rst_n = 1;
  endtask

  task automatic t_div;
    int c0, c1, f0, f1;
    int es[5] = '{0, 1, 3, 5, 8};
    gate = 2'b11; byp = 2'b00;
    foreach (es[k]) begin
      int n = 4 << es[k];
      if (n > 512) n = 512;
      reload(4'(es[k]), 2'd0);
      run(n, 1'b1, 1'b0, c0, c1, f0, f1);
      if (es[k] == 0) chk("R4 exp0 count", c0, n);
      else chk("R3 divided count", c0, n >> es[k]);
      chk("R3 first tick index", f0, (1 << es[k]) - 1);
      chk("R9 channels same count", c1, c0);
      chk("R9 channels same first", f1, f0);
    end
  endtask

  task automatic t_clamp;
    int c0, c1, f0, f1;
    gate = 2'b11; byp = 2'b00;
    reload(4'd12, 2'd0);
    run(512, 1'b1, 1'b0, c0, c1, f0, f1);
    chk("R5 exp12 count", c0, 2);
    chk("R5 exp12 first", f0, 255);
    reload(4'd15, 2'd1);
    run(300, 1'b0, 1'b1, c0, c1, f0, f1);
    chk("R5 exp15 first", f0, 255);
  endtask

  task automatic t_src;
    int c0, c1, f0, f1;
    gate = 2'b11; byp = 2'b00;
    reload(4'd1, 2'd0);
    run(8, 1'b0, 1'b1, c0, c1, f0, f1);
    chk("R2 sel0 ignores bus", c0, 0);
    run(8, 1'b1, 1'b0, c0, c1, f0, f1);
    chk("R2 sel0 uses osc", c0, 4);
    reload(4'd1, 2'd2);
    run(8, 1'b0, 1'b1, c0, c1, f0, f1);
    chk("R2 sel2 uses bus", c0, 4);
    reload(4'd1, 2'd3);
    run(8, 1'b1, 1'b0, c0, c1, f0, f1);
    chk("R2 sel3 ignores osc", c0, 0);
  endtask

  task automatic t_gate;
    int c0, c1, f0, f1;
    byp = 2'b00; gate = 2'b01;
    reload(4'd2, 2'd0);
    run(14, 1'b1, 1'b0, c0, c1, f0, f1);
    chk("R6 gated ch0 count", c0, 3);
    chk("R6 ungated ch1 silent", c1, 0);
    gate = 2'b11;
    run(6, 1'b1, 1'b0, c0, c1, f0, f1);
    chk("R6 counter kept running", f1, 1);
    chk("R9 both first", f0, f1);
  endtask

  task automatic t_bypass;
    int c0, c1, f0, f1;
    gate = 2'b11; byp = 2'b10;
    reload(4'd3, 2'd0);
    run(16, 1'b1, 1'b0, c0, c1, f0, f1);
    chk("R7 bypass ch1 every tick", c1, 16);
    chk("R7 divided ch0", c0, 2);
    gate = 2'b01;
    run(16, 1'b1, 1'b0, c0, c1, f0, f1);
    chk("R7 bypass still gated", c1, 0);
    byp = 2'b00;
  endtask

  task automatic t_restart;
    int c0, c1, f0, f1;
    gate = 2'b11; byp = 2'b00;
    reload(4'd3, 2'd0);
    run(5, 1'b1, 1'b0, c0, c1, f0, f1);
    chk("R8 no tick before change", c0, 0);
    @(negedge clk); osc = 1; dexp = 4'd2;
    #1 chk("R8 exp change cycle silent", int'(tick), 0);
    run(8, 1'b1, 1'b0, c0, c1, f0, f1);
    chk("R8 exp restart first", f0, 3);
    chk("R8 exp restart count", c0, 2);
    reload(4'd2, 2'd0);
    run(3, 1'b1, 1'b0, c0, c1, f0, f1);
    @(negedge clk); osc = 0; bus = 1; sel = 2'd1;
    #1 chk("R8 src change cycle silent", int'(tick), 0);
    run(4, 1'b0, 1'b1, c0, c1, f0, f1);
    chk("R8 src restart first", f0, 3);
  endtask

  initial begin
    #1000000;
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    t_reset();
    t_div();
    t_clamp();
    t_src();
    t_gate();
    t_bypass();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule